// File: doc/BRIEF.md
# H-Bridge Modified-Sine Gate Sequencer

This block drives the four switch gates of a full-bridge inverter so that the bridge produces a three-level, stepped approximation of a sine wave. A prescaler divides the system clock down to a step tick. A four-position ring then walks through four equal slots on that tick: a blank slot, a slot that drives one diagonal of the bridge, a second blank slot, and a slot that drives the other diagonal. Each blank slot is both the zero level of the waveform and the only dead time between the two polarities.

A select input picks a 50 Hz or a 60 Hz output. The step rate is four times the output frequency. The select is sampled only when a new output cycle begins, so every cycle that has started finishes at its original rate. While the enable is low or reset is asserted, every switch is held off. When the enable rises, the sequence restarts from the first blank slot. A one-clock strobe marks the start of each output cycle.

Top module: `hbridge_msine_seq`

## Requirements
- R1: While enabled, the slots repeat in the fixed order blank A, forward, blank B, reverse. Each slot lasts the same number of clocks. After reverse, the sequence wraps directly to blank A.
- R2: In the forward slot, `lo_b`=1, `hi_a_n`=0, `lo_a`=0 and `hi_b_n`=1. This means the high switch of leg A and the low switch of leg B are on.
- R3: In the reverse slot, `lo_a`=1, `hi_b_n`=0, `lo_b`=0 and `hi_a_n`=1. This means the high switch of leg B and the low switch of leg A are on.
- R4: In both blank slots, all switches are off: `lo_a`=`lo_b`=0 and `hi_a_n`=`hi_b_n`=1.
- R5: The two switches of one leg are never on together (`lo_x`=1 with `hi_x_n`=0). The outputs never pass from the forward pattern to the reverse pattern without a blank slot in between.
- R6: One slot lasts CLK_HZ/(4·LOW_HZ) clocks when `sel_60hz`=0, and CLK_HZ/(4·HIGH_HZ) clocks when `sel_60hz`=1.
- R7: `sel_60hz` is sampled only at the clock edge that starts an output cycle. A change in the middle of a cycle first affects the slot length of the next cycle.
- R8: The clock edge after `rst`=1 or `run_en`=0 is sampled leaves all switches off, as in R4. The first edge that samples `run_en`=1 after that starts blank A. The first slot change comes exactly one slot length after that edge.
- R9: `cycle_start` is high for exactly the one clock that follows each edge entering blank A. This covers both a start from idle and a wrap from reverse.
- R10: While enabled, the gate outputs change only at edges where the internal step tick is high. They are registered and change together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Run enable. Low forces all switches off and restarts the sequence |
| sel_60hz | input | 1 | 0 selects LOW_HZ output, 1 selects HIGH_HZ output |
| lo_a | output | 1 | Leg A low-side gate enable, active high |
| lo_b | output | 1 | Leg B low-side gate enable, active high |
| hi_a_n | output | 1 | Leg A high-side gate enable, active low |
| hi_b_n | output | 1 | Leg B high-side gate enable, active low |
| cycle_start | output | 1 | One-clock strobe on entry to blank A |

## Verification
The checker assumes that CLK_HZ is at least eight times the higher output frequency, so that each slot lasts at least two clocks. Its strobe and hold properties depend on that. It also assumes that `rst` is high at the first clock edge, so that the gate registers hold a known value before any property is evaluated. The bench overrides CLK_HZ with a small value that gives slots of 24 and 20 clocks. It holds reset through the first edges. It changes `run_en`, `sel_60hz` and `rst` only on falling clock edges, at points placed inside slots and across slot and cycle boundaries.

// File: rtl/hbsq_pkg.sv
package hbsq_pkg;

    typedef enum logic [1:0] {
        SLOT_BLANK_A = 2'd0,
        SLOT_FWD     = 2'd1,
        SLOT_BLANK_B = 2'd2,
        SLOT_REV     = 2'd3
    } slot_e;

    typedef struct packed {
        logic lo_a;
        logic lo_b;
        logic hi_a_n;
        logic hi_b_n;
    } gate_s;

    localparam gate_s GATES_OFF = '{lo_a: 1'b0, lo_b: 1'b0, hi_a_n: 1'b1, hi_b_n: 1'b1};
    localparam gate_s GATES_FWD = '{lo_a: 1'b0, lo_b: 1'b1, hi_a_n: 1'b0, hi_b_n: 1'b1};
    localparam gate_s GATES_REV = '{lo_a: 1'b1, lo_b: 1'b0, hi_a_n: 1'b1, hi_b_n: 1'b0};

    localparam int unsigned SLOTS_PER_CYCLE = 4;

    // Clocks per step slot for a given output frequency.
    function automatic int unsigned step_div(int unsigned clk_hz, int unsigned out_hz);
        return clk_hz / (SLOTS_PER_CYCLE * out_hz);
    endfunction

    function automatic gate_s slot_gates(slot_e s);
        gate_s g;
        case (s)
            SLOT_FWD: g = GATES_FWD;
            SLOT_REV: g = GATES_REV;
            default:  g = GATES_OFF;
        endcase
        return g;
    endfunction

    function automatic slot_e slot_after(slot_e s);
        slot_e n;
        case (s)
            SLOT_BLANK_A: n = SLOT_FWD;
            SLOT_FWD:     n = SLOT_BLANK_B;
            SLOT_BLANK_B: n = SLOT_REV;
            default:      n = SLOT_BLANK_A;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/hbsq_step_prescaler.sv
module hbsq_step_prescaler #(
    parameter int unsigned CLK_HZ  = 1_000_000,
    parameter int unsigned LOW_HZ  = 50,
    parameter int unsigned HIGH_HZ = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic use_high,
    output logic step_tick
);
    localparam int unsigned DIV_LO = hbsq_pkg::step_div(CLK_HZ, LOW_HZ);
    localparam int unsigned DIV_HI = hbsq_pkg::step_div(CLK_HZ, HIGH_HZ);
    localparam int unsigned DIV_MAX = (DIV_LO > DIV_HI) ? DIV_LO : DIV_HI;
    localparam int CNT_W = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
    localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(DIV_LO - 1);
    localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(DIV_HI - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    assign last      = use_high ? LAST_HI : LAST_LO;
    assign step_tick = active && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || !active || step_tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/hbsq_ring.sv
module hbsq_ring (
    input  logic           clk,
    input  logic           rst,
    input  logic           run_en,
    input  logic           sel_60hz,
    input  logic           step_tick,
    output logic           active,
    output logic           use_high,
    output hbsq_pkg::slot_e slot_d,
    output logic           cycle_entry
);
    import hbsq_pkg::*;

    slot_e slot_q;
    logic  active_q;
    logic  use_high_q;
    logic  active_d;
    logic  use_high_d;

    always_comb begin
        slot_d      = slot_q;
        active_d    = active_q;
        use_high_d  = use_high_q;
        cycle_entry = 1'b0;
        if (rst || !run_en) begin
            slot_d     = SLOT_BLANK_A;
            active_d   = 1'b0;
            use_high_d = sel_60hz;
        end else if (!active_q) begin
            slot_d      = SLOT_BLANK_A;
            active_d    = 1'b1;
            use_high_d  = sel_60hz;
            cycle_entry = 1'b1;
        end else if (step_tick) begin
            slot_d = slot_after(slot_q);
            if (slot_q == SLOT_REV) begin
                use_high_d  = sel_60hz;
                cycle_entry = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        slot_q     <= slot_d;
        active_q   <= active_d;
        use_high_q <= use_high_d;
    end

    assign active   = active_q;
    assign use_high = use_high_q;
endmodule

// File: rtl/hbsq_gate_reg.sv
module hbsq_gate_reg (
    input  logic            clk,
    input  logic            rst,
    input  hbsq_pkg::slot_e slot_d,
    input  logic            cycle_entry,
    output hbsq_pkg::gate_s gates,
    output logic            strobe
);
    import hbsq_pkg::*;

    gate_s gates_q;
    logic  strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gates_q  <= GATES_OFF;
            strobe_q <= 1'b0;
        end else begin
            gates_q  <= slot_gates(slot_d);
            strobe_q <= cycle_entry;
        end
    end

    assign gates  = gates_q;
    assign strobe = strobe_q;
endmodule

// File: rtl/hbridge_msine_seq.sv
module hbridge_msine_seq #(
    parameter int unsigned CLK_HZ  = 1_000_000,
    parameter int unsigned LOW_HZ  = 50,
    parameter int unsigned HIGH_HZ = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    input  logic sel_60hz,
    output logic lo_a,
    output logic lo_b,
    output logic hi_a_n,
    output logic hi_b_n,
    output logic cycle_start
);
    import hbsq_pkg::*;

    logic  step_tick;
    logic  active;
    logic  use_high;
    logic  cycle_entry;
    slot_e slot_d;
    gate_s gates;

    hbsq_step_prescaler #(
        .CLK_HZ (CLK_HZ),
        .LOW_HZ (LOW_HZ),
        .HIGH_HZ(HIGH_HZ)
    ) u_presc (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .use_high (use_high),
        .step_tick(step_tick)
    );

    hbsq_ring u_ring (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .sel_60hz   (sel_60hz),
        .step_tick  (step_tick),
        .active     (active),
        .use_high   (use_high),
        .slot_d     (slot_d),
        .cycle_entry(cycle_entry)
    );

    hbsq_gate_reg u_gates (
        .clk        (clk),
        .rst        (rst),
        .slot_d     (slot_d),
        .cycle_entry(cycle_entry),
        .gates      (gates),
        .strobe     (cycle_start)
    );

    assign lo_a   = gates.lo_a;
    assign lo_b   = gates.lo_b;
    assign hi_a_n = gates.hi_a_n;
    assign hi_b_n = gates.hi_b_n;
endmodule

// File: rtl/hbsq_checker.sv
module hbsq_checker (
    input logic clk,
    input logic rst,
    input logic run_en,
    input logic step_tick,
    input logic lo_a,
    input logic lo_b,
    input logic hi_a_n,
    input logic hi_b_n,
    input logic cycle_start
);
    logic all_off;
    logic fwd_on;
    logic rev_on;

    assign all_off = !lo_a && !lo_b && hi_a_n && hi_b_n;
    assign fwd_on  = lo_b && !hi_a_n;
    assign rev_on  = lo_a && !hi_b_n;

    AST_LEG_A_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(lo_a && !hi_a_n)); // R5
    AST_LEG_B_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(lo_b && !hi_b_n)); // R5
    AST_FWD_NOT_INTO_REV: assert property (@(posedge clk) disable iff (rst)
        fwd_on |=> !rev_on); // R5
    AST_REV_NOT_INTO_FWD: assert property (@(posedge clk) disable iff (rst)
        rev_on |=> !fwd_on); // R5
    AST_OFF_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> all_off); // R8
    AST_STROBE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        cycle_start |=> !cycle_start); // R9
    AST_STROBE_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
        cycle_start |-> all_off); // R9
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
        (run_en && !step_tick) |=> $stable({lo_a, lo_b, hi_a_n, hi_b_n})); // R10
endmodule

bind hbridge_msine_seq hbsq_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .step_tick  (step_tick),
    .lo_a       (lo_a),
    .lo_b       (lo_b),
    .hi_a_n     (hi_a_n),
    .hi_b_n     (hi_b_n),
    .cycle_start(cycle_start)
);

// File: tb/hbridge_msine_seq_tb.sv
module hbridge_msine_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int unsigned BENCH_CLK_HZ = 4800;
    localparam int T50 = BENCH_CLK_HZ / (4 * 50);
    localparam int T60 = BENCH_CLK_HZ / (4 * 60);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_en = 1'b0;
    logic sel_60hz = 1'b0;
    logic lo_a, lo_b, hi_a_n, hi_b_n, cycle_start;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference state, derived from the requirements
    bit m_active = 1'b0;
    int m_t = 0;
    int m_term = T50;
    bit m_strobe = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hbridge_msine_seq #(
        .CLK_HZ (BENCH_CLK_HZ),
        .LOW_HZ (50),
        .HIGH_HZ(60)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .sel_60hz   (sel_60hz),
        .lo_a       (lo_a),
        .lo_b       (lo_b),
        .hi_a_n     (hi_a_n),
        .hi_b_n     (hi_b_n),
        .cycle_start(cycle_start)
    );

    // Advance the reference by one clock edge (R1, R6, R7, R8, R9).
    task automatic model_edge();
        if (rst || !run_en) begin
            m_active = 1'b0;
            m_t = 0;
            m_strobe = 1'b0;
        end else if (!m_active) begin
            m_active = 1'b1;
            m_t = 0;
            m_term = sel_60hz ? T60 : T50;
            m_strobe = 1'b1;
        end else begin
            m_t++;
            m_strobe = 1'b0;
            if (m_t == 4 * m_term) begin
                m_t = 0;
                m_term = sel_60hz ? T60 : T50;
                m_strobe = 1'b1;
            end
        end
    endtask

    task automatic check_now(string note);
        logic [3:0] exp_g;
        logic [3:0] got_g;
        string tag;
        int slot;
        slot = m_active ? (m_t / m_term) : 0;
        if (!m_active) begin
            exp_g = 4'b0011; tag = "R8";
        end else if (slot == 1) begin
            exp_g = 4'b0101; tag = "R2";
        end else if (slot == 3) begin
            exp_g = 4'b1010; tag = "R3";
        end else begin
            exp_g = 4'b0011; tag = "R4";
        end
        got_g = {lo_a, lo_b, hi_a_n, hi_b_n};
        n_vec++;
        if (got_g !== exp_g) begin
            n_bad++;
            $display("FAIL %s (%s) t=%0d gates {lo_a,lo_b,hi_a_n,hi_b_n} got %b expected %b",
                     tag, note, m_t, got_g, exp_g);
        end
        n_vec++;
        if (cycle_start !== m_strobe) begin
            n_bad++;
            $display("FAIL R9 (%s) t=%0d cycle_start got %b expected %b",
                     note, m_t, cycle_start, m_strobe);
        end
    endtask

    task automatic step(int n, string note);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            check_now(note);
        end
    endtask

    // R8: outputs off under reset and while disabled
    task automatic t_reset();
        rst = 1'b1; run_en = 1'b0;
        step(3, "reset held R8");
        rst = 1'b0;
        step(3, "idle disabled R8");
    endtask

    // R1 R2 R3 R4 R6 R9 R10: two full cycles at the low rate
    task automatic t_run_low();
        sel_60hz = 1'b0; run_en = 1'b1;
        step(8 * T50 + 2, "low rate R1 R6");
    endtask

    // R6: restart at the high rate
    task automatic t_run_high();
        run_en = 1'b0;
        step(2, "stop R8");
        sel_60hz = 1'b1; run_en = 1'b1;
        step(8 * T60 + 2, "high rate R6");
    endtask

    // R7: select flips mid-cycle, only the next cycle follows it
    task automatic t_sel_midcycle();
        run_en = 1'b0;
        step(1, "stop R8");
        sel_60hz = 1'b0; run_en = 1'b1;
        step(T50 + 5, "sel low start R7");
        sel_60hz = 1'b1;
        step(3 * T50 + 2 * T60, "sel flipped in forward R7");
        sel_60hz = 1'b0;
        step(T60 - 1, "sel flipped back before wrap R7");
        step(4 * T60 + 4 * T50 + 3, "after wrap R7");
    endtask

    // R8 R9: disable in forward slot, then re-enable restarts at blank A
    task automatic t_stop_mid();
        sel_60hz = 1'b1;
        run_en = 1'b0;
        step(1, "stop R8");
        run_en = 1'b1;
        step(T60 + 3, "into forward R2");
        run_en = 1'b0;
        step(3, "disabled mid forward R8");
        run_en = 1'b1;
        step(4 * T60 + 2, "restart R9");
    endtask

    // R5 R8: reset while the reverse slot is driving
    task automatic t_reset_mid();
        step(3 * T60, "into reverse R3");
        rst = 1'b1;
        step(2, "reset mid reverse R8");
        rst = 1'b0;
        step(4 * T60 + 4, "after reset R5");
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_run_low();
        t_run_high();
        t_sel_midcycle();
        t_stop_mid();
        t_reset_mid();
        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R1 watchdog: got run still active, expected completion");
            report();
            $finish;
        end
    end
endmodule